// File: doc/BRIEF.md
# Unaligned Access Fragment Splitter

This block sits between a processor's load/store port and a physical port organised in 32-bit longwords. It accepts one word (2-byte) or longword (4-byte) access at any byte offset. It converts that access into one or two fragment transfers that carry exactly the bytes the access needs. The block never reads the surrounding longword back and merges into it.

When an access runs past the end of its longword, the remaining bytes go to a second physical address. The requester supplies this address separately, because the next longword may sit on a different page. The splitter clears the low two bits of that address, so the upper bytes always land at the bottom of the second longword.

For loads, the two fragments are merged into one right-aligned result. For stores, the store value is cut into right-aligned, masked pieces. An error response on either fragment ends the sequence early and is reported with the completion pulse.

Top module: `splitter_top`

## Requirements
- R1: A word at byte offset 0, 1 or 2 is issued as exactly one fragment of length 2 at `reqAddr`. A longword at offset 0 is issued as exactly one fragment of length 4 at `reqAddr`. The byte offset is `reqAddr[1:0]`, and `reqLong`=1 selects a longword.
- R2: A longword at byte offset b (1 to 3) is issued in two fragments. The first carries 4−b bytes at `reqAddr`. The second carries b bytes at `reqAddrNext` with its two low bits cleared.
- R3: A word at byte offset 3 is issued as two 1-byte fragments. The first goes to `reqAddr`. The second goes to `reqAddrNext` with its two low bits cleared.
- R4: A split longword load returns first | (second << (32−8b)), truncated to 32 bits. Each piece is taken right-aligned and masked to its fragment length.
- R5: A split word load returns first | (second << 8). For every load, bits of `fragRdata` above the fragment length have no effect on `doneRdata`.
- R6: For a store, the first fragment carries the store value masked to its length. The second carries the store value shifted right by 8 × (length of the first fragment), masked to its own length. Both are right-aligned.
- R7: The first-address fragment is always issued before the second-address fragment. `fragValid`, `fragAddr`, `fragLen` and `fragWdata` hold steady until `fragAck`.
- R8: `doneValid` is high for exactly one cycle, starting in the cycle after the acknowledge of the last fragment. `reqReady` is low from acceptance until that pulse has ended.
- R9: `fragErr` together with `fragAck` on any fragment stops the sequence. No further fragment is issued, and `doneErr` is high with `doneValid`. Otherwise `doneErr` is low.
- R10: After reset, `fragValid` and `doneValid` are low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request strobe |
| reqReady | output | 1 | Splitter idle, request accepted this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqLong | input | 1 | 1 = longword, 0 = word |
| reqAddr | input | ADDR_W | Physical address of first byte |
| reqAddrNext | input | ADDR_W | Physical address within the following longword |
| reqWdata | input | 32 | Right-aligned store data |
| doneValid | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | A fragment returned an error |
| doneRdata | output | 32 | Right-aligned load result |
| fragValid | output | 1 | Fragment request pending |
| fragWrite | output | 1 | Fragment direction |
| fragAddr | output | ADDR_W | Fragment physical address |
| fragLen | output | 3 | Fragment length in bytes (1 to 4) |
| fragWdata | output | 32 | Right-aligned, masked fragment store data |
| fragAck | input | 1 | Fragment accepted and completed |
| fragErr | input | 1 | Fragment error response, valid with fragAck |
| fragRdata | input | 32 | Fragment load data, low bytes significant |

## Verification
The bench sweeps every byte offset for both sizes and both directions, with acknowledge delays of zero and two cycles. In each case it compares the fragment count, the addresses, the lengths and the merged or sliced data against a byte-count model.

A design that mistakes which word offsets stay inside one longword would issue an extra fragment at offset 1 or 2, or a single 2-byte fragment at offset 3. A wrong merge shift scrambles the upper bytes of a longword load. A design that forgot to mask would leak the junk the bench puts above each fragment's length. If the second address were not aligned, or were derived from the first address, the bench's deliberately distant next address would expose it.

Error cases on the first and on the second fragment check that nothing more is issued and that the completion reports the error.

// File: rtl/splitPkg.sv
package splitPkg;
  localparam int LW_BITS = 32;
  localparam int LEN_W   = 3;

  typedef struct packed {
    logic capReq;
    logic capLow;
    logic capHigh;
    logic selHigh;
  } ctrlStrobes_t;

  function automatic logic [LW_BITS-1:0] lenMask(input logic [LEN_W-1:0] len);
    logic [LW_BITS-1:0] m;
    case (len)
      3'd1:    m = 32'h0000_00FF;
      3'd2:    m = 32'h0000_FFFF;
      3'd3:    m = 32'h00FF_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/splitDatapath.sv
module splitDatapath
  import splitPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic                reqWrite,
  input  logic                reqLong,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [ADDR_W-1:0]   reqAddrNext,
  input  logic [LW_BITS-1:0]  reqWdata,
  input  logic [LW_BITS-1:0]  fragRdata,
  output logic                needTwo,
  output logic                fragWrite,
  output logic [ADDR_W-1:0]   fragAddr,
  output logic [LEN_W-1:0]    fragLen,
  output logic [LW_BITS-1:0]  fragWdata,
  output logic [LW_BITS-1:0]  rdataOut
);
  localparam int SH_W = $clog2(LW_BITS) + 1;

  logic                writeQ, longQ;
  logic [ADDR_W-1:0]   addrQ, nextQ;
  logic [LW_BITS-1:0]  wdataQ, rdataQ;
  logic [1:0]          byteOff;
  logic [LEN_W-1:0]    lowLen, highLen;
  logic [SH_W-1:0]     highShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeQ <= 1'b0;
      longQ  <= 1'b0;
      addrQ  <= '0;
      nextQ  <= '0;
      wdataQ <= '0;
    end else if (strb.capReq) begin
      writeQ <= reqWrite;
      longQ  <= reqLong;
      addrQ  <= reqAddr;
      nextQ  <= reqAddrNext;
      wdataQ <= reqWdata;
    end
  end

  always_comb begin
    byteOff = addrQ[1:0];
    needTwo = longQ ? (byteOff != 2'd0) : (byteOff == 2'd3);
    if (!needTwo)    lowLen = longQ ? 3'd4 : 3'd2;
    else if (longQ)  lowLen = 3'd4 - {1'b0, byteOff};
    else             lowLen = 3'd1;
    highLen   = longQ ? {1'b0, byteOff} : 3'd1;
    highShift = longQ ? (SH_W'(LW_BITS) - {1'b0, byteOff, 3'b000}) : SH_W'(8);
  end

  assign fragWrite = writeQ;
  assign fragAddr  = strb.selHigh ? {nextQ[ADDR_W-1:2], 2'b00} : addrQ;
  assign fragLen   = strb.selHigh ? highLen : lowLen;
  assign fragWdata = strb.selHigh ? ((wdataQ >> highShift) & lenMask(highLen))
                                  : (wdataQ & lenMask(lowLen));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdataQ <= '0;
    else if (strb.capReq)  rdataQ <= '0;
    else if (strb.capLow)  rdataQ <= fragRdata & lenMask(lowLen);
    else if (strb.capHigh) rdataQ <= rdataQ | ((fragRdata & lenMask(highLen)) << highShift);
  end

  assign rdataOut = rdataQ;

  // R2
  high_needs_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capHigh |-> needTwo);
  // R3
  high_len_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.selHigh |-> (fragLen != 3'd0 && fragLen != 3'd4));
endmodule

// File: rtl/splitControl.sv
module splitControl
  import splitPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         needTwo,
  input  logic         fragAck,
  input  logic         fragErr,
  output logic         reqReady,
  output logic         fragValid,
  output logic         doneValid,
  output logic         doneErr,
  output ctrlStrobes_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_DONE} splitState_t;

  splitState_t state, stateNext;
  logic        errQ, errNext;

  always_comb begin
    stateNext = state;
    errNext   = errQ;
    case (state)
      ST_IDLE: if (reqValid) begin
        stateNext = ST_LOW;
        errNext   = 1'b0;
      end
      ST_LOW: if (fragAck) begin
        if (fragErr) begin
          stateNext = ST_DONE;
          errNext   = 1'b1;
        end else begin
          stateNext = needTwo ? ST_HIGH : ST_DONE;
        end
      end
      ST_HIGH: if (fragAck) begin
        stateNext = ST_DONE;
        errNext   = fragErr;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      errQ  <= 1'b0;
    end else begin
      state <= stateNext;
      errQ  <= errNext;
    end
  end

  assign reqReady     = (state == ST_IDLE);
  assign fragValid    = (state == ST_LOW) || (state == ST_HIGH);
  assign doneValid    = (state == ST_DONE);
  assign doneErr      = (state == ST_DONE) && errQ;
  assign strb.capReq  = (state == ST_IDLE) && reqValid;
  assign strb.capLow  = (state == ST_LOW) && fragAck && !fragErr;
  assign strb.capHigh = (state == ST_HIGH) && fragAck && !fragErr;
  assign strb.selHigh = (state == ST_HIGH);

  // R7
  frag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fragValid && !fragAck) |=> fragValid);
  // R7
  high_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.selHigh) |-> ($past(state) == ST_LOW));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fragValid || doneValid) |-> !reqReady);
  // R9
  err_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fragValid && fragAck && fragErr) |=> (doneValid && doneErr));
endmodule

// File: rtl/splitter_top.sv
module splitter_top
  import splitPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqLong,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] reqAddrNext,
  input  logic [31:0]       reqWdata,
  output logic              doneValid,
  output logic              doneErr,
  output logic [31:0]       doneRdata,
  output logic              fragValid,
  output logic              fragWrite,
  output logic [ADDR_W-1:0] fragAddr,
  output logic [2:0]        fragLen,
  output logic [31:0]       fragWdata,
  input  logic              fragAck,
  input  logic              fragErr,
  input  logic [31:0]       fragRdata
);
  ctrlStrobes_t strb;
  logic         needTwo;

  splitControl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .needTwo(needTwo),
    .fragAck(fragAck), .fragErr(fragErr), .reqReady(reqReady),
    .fragValid(fragValid), .doneValid(doneValid), .doneErr(doneErr), .strb(strb)
  );

  splitDatapath #(.ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWrite(reqWrite), .reqLong(reqLong),
    .reqAddr(reqAddr), .reqAddrNext(reqAddrNext), .reqWdata(reqWdata),
    .fragRdata(fragRdata), .needTwo(needTwo), .fragWrite(fragWrite),
    .fragAddr(fragAddr), .fragLen(fragLen), .fragWdata(fragWdata), .rdataOut(doneRdata)
  );
endmodule

// File: tb/sim_splitter_top.sv
`timescale 1ns/1ps
module sim_splitter_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqLong = 1'b0;
  logic [31:0] reqAddr = '0, reqAddrNext = '0, reqWdata = '0;
  logic reqReady, doneValid, doneErr, fragValid, fragWrite;
  logic [31:0] doneRdata, fragAddr, fragWdata;
  logic [2:0] fragLen;
  logic fragAck = 1'b0, fragErr = 1'b0;
  logic [31:0] fragRdata = '0;

  int checks = 0;
  int errors = 0;
  bit allDone = 1'b0;

  always #2.5 clk = ~clk;

  splitter_top #(.ADDR_W(32)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqLong(reqLong), .reqAddr(reqAddr),
    .reqAddrNext(reqAddrNext), .reqWdata(reqWdata), .doneValid(doneValid),
    .doneErr(doneErr), .doneRdata(doneRdata), .fragValid(fragValid),
    .fragWrite(fragWrite), .fragAddr(fragAddr), .fragLen(fragLen),
    .fragWdata(fragWdata), .fragAck(fragAck), .fragErr(fragErr), .fragRdata(fragRdata)
  );

  function automatic logic [31:0] byteMask(input int n);
    logic [31:0] m = '0;
    for (int i = 0; i < n; i++) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [31:0] memVal(input logic [31:0] a, input int n);
    return (a * 32'h0101_0107 + 32'h3C5A_9611) & byteMask(n);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runOp(input bit wr, input bit lng, input logic [31:0] a,
                       input logic [31:0] nx, input logic [31:0] wd,
                       input int errAt, input int dly);
    int bo, n, lowLen, highLen, expCnt, nFr, guard;
    logic [31:0] gAddr[2], gWd[2], gLen[2];
    logic [31:0] lowV, highV, nxA, rdGot;
    bit doneSeen, errGot;
    string sTag;
    bo = int'(a[1:0]);
    n  = lng ? 4 : 2;
    if (bo + n > 4) begin lowLen = 4 - bo; highLen = n - lowLen; end
    else begin lowLen = n; highLen = 0; end
    nxA = {nx[31:2], 2'b00};
    expCnt = (errAt == 1) ? 1 : ((highLen != 0) ? 2 : 1);
    sTag = (highLen == 0) ? "R1" : (lng ? "R2" : "R3");

    @(negedge clk);
    chk(reqReady, "R8 ready before op", 32'(reqReady), 1);
    reqValid = 1'b1; reqWrite = wr; reqLong = lng;
    reqAddr = a; reqAddrNext = nx; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R8 busy after accept", 32'(reqReady), 0);

    nFr = 0; guard = 0; doneSeen = 1'b0; errGot = 1'b0; rdGot = '0;
    while (!doneSeen && guard < 40) begin
      guard++;
      if (doneValid) begin
        doneSeen = 1'b1; errGot = doneErr; rdGot = doneRdata;
      end else if (fragValid) begin
        if (nFr < 2) begin
          gAddr[nFr] = fragAddr; gLen[nFr] = 32'(fragLen); gWd[nFr] = fragWdata;
        end
        chk(fragWrite == wr, "R7 fragment direction", 32'(fragWrite), 32'(wr));
        for (int d = 0; d < dly; d++) begin
          @(negedge clk);
          chk(fragValid && fragAddr == gAddr[nFr & 1] && 32'(fragLen) == gLen[nFr & 1]
              && fragWdata == gWd[nFr & 1], "R7 hold until ack", fragAddr, gAddr[nFr & 1]);
        end
        fragAck = 1'b1;
        fragErr = (errAt == nFr + 1);
        fragRdata = memVal(fragAddr, int'(fragLen)) | (~byteMask(int'(fragLen)) & 32'hA5C3_E10F);
        nFr++;
        @(negedge clk);
        fragAck = 1'b0; fragErr = 1'b0; fragRdata = '0;
      end else begin
        @(negedge clk);
      end
    end

    chk(doneSeen, "R8 done seen", 32'(doneSeen), 1);
    chk(nFr == expCnt, {sTag, " fragment count"}, 32'(nFr), 32'(expCnt));
    if (nFr >= 1) begin
      chk(gAddr[0] == a, {sTag, " first address"}, gAddr[0], a);
      chk(gLen[0] == 32'(lowLen), {sTag, " first length"}, gLen[0], 32'(lowLen));
      if (wr) chk(gWd[0] == (wd & byteMask(lowLen)), "R6 first store data",
                  gWd[0], wd & byteMask(lowLen));
    end
    if (nFr >= 2 && expCnt == 2) begin
      chk(gAddr[1] == nxA, {sTag, " second address"}, gAddr[1], nxA);
      chk(gLen[1] == 32'(highLen), {sTag, " second length"}, gLen[1], 32'(highLen));
      if (wr) chk(gWd[1] == ((wd >> (8 * lowLen)) & byteMask(highLen)), "R6 second store data",
                  gWd[1], (wd >> (8 * lowLen)) & byteMask(highLen));
    end
    chk(errGot == (errAt != 0), "R9 error flag", 32'(errGot), 32'(errAt != 0));
    if (!wr && errAt == 0) begin
      lowV  = memVal(a, lowLen);
      highV = (highLen != 0) ? memVal(nxA, highLen) : 32'h0;
      if (lng) chk(rdGot == (lowV | (highV << (8 * lowLen))), "R4 longword merge",
                   rdGot, lowV | (highV << (8 * lowLen)));
      else     chk(rdGot == (lowV | (highV << (8 * lowLen))), "R5 word merge",
                   rdGot, lowV | (highV << (8 * lowLen)));
    end
    @(negedge clk);
    chk(!doneValid && reqReady, "R8 single-cycle done", 32'(doneValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!fragValid, "R10 fragValid at reset", 32'(fragValid), 0);
    chk(!doneValid, "R10 doneValid at reset", 32'(doneValid), 0);
    chk(reqReady, "R10 reqReady at reset", 32'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    for (int w = 0; w < 2; w++)
      for (int l = 0; l < 2; l++)
        for (int b = 0; b < 4; b++)
          for (int d = 0; d < 3; d += 2)
            runOp(w[0], l[0], 32'h0001_2340 + 32'(b) + 32'(16 * d),
                  32'h0077_8000 + 32'(b * 5), 32'h8E4D_2B71 ^ 32'(b * 32'h1111_0000 + l * 7),
                  0, d);
    runOp(1'b0, 1'b1, 32'h0000_4002, 32'h0009_1003, 32'h0, 1, 0);
    runOp(1'b0, 1'b1, 32'h0000_4001, 32'h0009_1002, 32'h0, 2, 1);
    runOp(1'b1, 1'b0, 32'h0000_4003, 32'h0009_1001, 32'hBEEF, 2, 0);
    runOp(1'b1, 1'b1, 32'h0000_4000, 32'h0009_1000, 32'h1234_5678, 1, 0);
    runOp(1'b0, 1'b1, 32'h0000_0FFF, 32'h0005_3000, 32'h0, 0, 0);
    allDone = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!allDone) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule